// File: doc/BRIEF.md
# Single-Step Trace Request Sequencer

This block decides, for every instruction that completes, whether a single-step trace exception must be requested, and captures the program counter and status register values that the exception frame will hold. It watches a completion strobe with the completing instruction's address and length, the current status register with its trace-enable flag at bit 15, a flag that marks the completing instruction as the low-power halt instruction (called STOP below), and that instruction's immediate operand.

An ordinary instruction is traced whenever trace mode is on. The stacked address is that of the next instruction, so the instruction just before a STOP stacks the STOP's own address. STOP is handled separately. When it completes it loads its immediate operand into the status register. It is traced when tracing was already on, or when the new value turns tracing on. Its frame holds the following instruction's address and the newly loaded status value. A completing instruction that raised some other exception gets no trace. That trace is dropped, not held back: only one exception frame exists at a time, and the other exception's handler is responsible for checking for trace mode. Frame building, vector fetch and the halt itself belong to neighbouring logic.

Top module: `trace_seq`

## Requirements
- R1: After reset `traceReq` is 0 and `stackPc` and `stackSr` are all zeros.
- R2: A completion (`retireValid`=1) of an instruction with `isStop`=0, `retireExc`=0 and `srCur[15]`=1 drives `traceReq` to 1 in the next cycle. In that cycle `stackPc` equals `retirePc + 2*retireLen` (length counted in 16-bit words) and `stackSr` equals `srCur`.
- R3: A completion with `isStop`=0 and `srCur[15]`=0 leaves `traceReq` at 0, and `stackPc` and `stackSr` keep their previous values.
- R4: With trace on, the instruction that precedes a STOP is traced with `stackPc` equal to the STOP's address. The STOP that follows is then traced again, with the address after the STOP.
- R5: A STOP completion (`isStop`=1, `retireExc`=0) with `srCur[15]`=1 raises `traceReq` in the next cycle, even when `stopImm[15]`=0. In that cycle `stackSr` equals `stopImm` and `stackPc` equals `retirePc + 2*retireLen`.
- R6: A STOP completion with `srCur[15]`=0 and `stopImm[15]`=1 raises `traceReq` in the next cycle, with the same frame values as R5.
- R7: A STOP completion with both `srCur[15]`=0 and `stopImm[15]`=0 raises no trace, and the frame outputs are unchanged.
- R8: A completion with `retireExc`=1 raises no trace in the next cycle or in any later cycle, and the frame outputs are unchanged.
- R9: `traceReq` is high for exactly one cycle per traced completion. Completions in consecutive cycles give pulses in consecutive cycles, each with its own frame values.
- R10: The stacked address wraps modulo 2^ADDR_W.
- R11: Every length from 1 to 2^LEN_W-1 words advances the stacked address by twice that length in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | Instruction completion strobe |
| retirePc | input | ADDR_W | Address of the completing instruction |
| retireLen | input | LEN_W | Length of the completing instruction in 16-bit words |
| retireExc | input | 1 | The completing instruction raised another exception |
| srCur | input | SR_W | Status register at completion; bit 15 enables tracing |
| isStop | input | 1 | The completing instruction is STOP |
| stopImm | input | SR_W | STOP immediate operand, loaded into the status register |
| traceReq | output | 1 | One-cycle trace exception request |
| stackPc | output | ADDR_W | Program counter for the exception frame |
| stackSr | output | SR_W | Status register value for the exception frame |

## Verification
The sweep covers every combination of old trace flag, STOP marker, new trace flag in the immediate operand and competing exception, at every legal length. This separates the plain trace path from both STOP trigger paths, shows that the competing exception always wins, and shows that the stacked status value comes from the right source. A directed pair, made of an instruction followed by a STOP, shows that one STOP yields two traces with different stacked addresses. Back-to-back completions show that neighbouring pulses do not merge, and an address near the top of the range exercises wrap-around. Each check is followed by an idle cycle, which confirms that a suppressed trace never appears later.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
  // Strobes from control to datapath for a single cycle.
  typedef struct packed {
    logic loadFrame;  // capture frame values this cycle
    logic useStopSr;  // stacked status comes from the STOP operand
  } seqStrobe_t;
endpackage

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
  import trace_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retireValid,
  input  logic       retireExc,
  input  logic       isStop,
  input  logic       curTrace,
  input  logic       newTrace,
  output seqStrobe_t strobe,
  output logic       traceReq
);
  logic plainHit;
  logic stopHit;
  logic fire;

  // Ordinary instruction: traced only when trace mode is on.
  // STOP: traced if tracing was on or the loaded value turns it on.
  always_comb begin
    plainHit = !isStop && curTrace;
    stopHit  = isStop && (curTrace || newTrace);
    fire     = retireValid && !retireExc && (plainHit || stopHit);
    strobe.loadFrame = fire;
    strobe.useStopSr = isStop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) traceReq <= 1'b0;
    else       traceReq <= fire;
  end

  AST_REQ_FOLLOWS_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    traceReq |-> $past(retireValid));  // R9
  AST_EXC_SUPPRESSES: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && retireExc) |=> !traceReq);  // R8
  AST_STOP_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && isStop && !retireExc && newTrace) |=> traceReq);  // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !isStop && !curTrace) |=> !traceReq);  // R3
  AST_STOP_OLD_TRACE: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && isStop && !retireExc && curTrace) |=> traceReq);  // R5
endmodule

// File: rtl/trace_seq_dp.sv
module trace_seq_dp
  import trace_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3,
  parameter int SR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] retirePc,
  input  logic [LEN_W-1:0]  retireLen,
  input  logic [SR_W-1:0]   srCur,
  input  logic [SR_W-1:0]   stopImm,
  output logic [ADDR_W-1:0] stackPc,
  output logic [SR_W-1:0]   stackSr
);
  localparam int STEP_W = LEN_W + 1;

  logic [STEP_W-1:0] stepBytes;
  logic [ADDR_W-1:0] nextPc;
  logic [SR_W-1:0]   frameSr;

  always_comb begin
    stepBytes = {retireLen, 1'b0};
    nextPc    = retirePc + ADDR_W'(stepBytes);
    frameSr   = strobe.useStopSr ? stopImm : srCur;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackPc <= '0;
      stackSr <= '0;
    end else if (strobe.loadFrame) begin
      stackPc <= nextPc;
      stackSr <= frameSr;
    end
  end

  AST_FRAME_HOLD_PC: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFrame |=> $stable(stackPc));  // R3
  AST_FRAME_HOLD_SR: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFrame |=> $stable(stackSr));  // R7
  AST_STOP_SR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFrame && strobe.useStopSr) |=> (stackSr == $past(stopImm)));  // R5
endmodule

// File: rtl/trace_seq.sv
module trace_seq
  import trace_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 3,
  parameter int SR_W      = 16,
  parameter int TRACE_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retirePc,
  input  logic [LEN_W-1:0]  retireLen,
  input  logic              retireExc,
  input  logic [SR_W-1:0]   srCur,
  input  logic              isStop,
  input  logic [SR_W-1:0]   stopImm,
  output logic              traceReq,
  output logic [ADDR_W-1:0] stackPc,
  output logic [SR_W-1:0]   stackSr
);
  seqStrobe_t strobe;

  trace_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .retireValid(retireValid),
    .retireExc  (retireExc),
    .isStop     (isStop),
    .curTrace   (srCur[TRACE_BIT]),
    .newTrace   (stopImm[TRACE_BIT]),
    .strobe     (strobe),
    .traceReq   (traceReq)
  );

  trace_seq_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SR_W(SR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .retirePc (retirePc),
    .retireLen(retireLen),
    .srCur    (srCur),
    .stopImm  (stopImm),
    .stackPc  (stackPc),
    .stackSr  (stackSr)
  );

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (traceReq && !$past(retireValid && !retireExc)) |-> 1'b0);  // R9
endmodule

// File: tb/trace_seq_test.sv
module trace_seq_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid;
  logic [31:0] retirePc;
  logic [2:0]  retireLen;
  logic        retireExc;
  logic [15:0] srCur;
  logic        isStop;
  logic [15:0] stopImm;
  logic        traceReq;
  logic [31:0] stackPc;
  logic [15:0] stackSr;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [31:0] expPc;
  logic [15:0] expSr;

  always #5 clk = ~clk;

  trace_seq uut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retirePc(retirePc),
    .retireLen(retireLen), .retireExc(retireExc), .srCur(srCur), .isStop(isStop),
    .stopImm(stopImm), .traceReq(traceReq), .stackPc(stackPc), .stackSr(stackSr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one completion at a falling edge; results are sampled one falling edge later.
  task automatic drive(input logic [31:0] pc, input logic [2:0] len, input logic [15:0] sr,
                       input logic stp, input logic [15:0] imm, input logic exc);
    retireValid = 1'b1; retirePc = pc; retireLen = len; srCur = sr;
    isStop = stp; stopImm = imm; retireExc = exc;
  endtask

  task automatic idle();
    retireValid = 1'b0; retireExc = 1'b0; isStop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idle(); retirePc = '0; retireLen = '0; srCur = '0; stopImm = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 traceReq", 32'(traceReq), 0);
    chk("R1 stackPc", stackPc, 0);
    chk("R1 stackSr", 32'(stackSr), 0);
    rstN = 1'b1;
    expPc = '0; expSr = '0;
    @(negedge clk);

    // Sweep: length x old trace x STOP x new trace x competing exception (R2 R3 R5 R6 R7 R8 R11)
    for (int len = 1; len < 8; len++) begin
      for (int k = 0; k < 16; k++) begin
        logic t, s, n, e, fire;
        logic [31:0] pc;
        logic [15:0] sr, imm;
        t = k[0]; s = k[1]; n = k[2]; e = k[3];
        pc  = 32'h1000 + 32'(len * 256 + k * 16);
        sr  = {t, 15'(len * 37 + k * 5)};
        imm = {n, 15'(len * 91 + k * 11)};
        fire = !e && (s ? (t || n) : t);
        drive(pc, 3'(len), sr, s, imm, e);
        @(negedge clk);
        idle();
        if (fire) begin
          expPc = pc + 32'(2 * len);
          expSr = s ? imm : sr;
        end
        if (e)            chk("R8 suppressed by exception", 32'(traceReq), 0);
        else if (!s)      chk(t ? "R2 plain trace" : "R3 trace off", 32'(traceReq), 32'(t));
        else if (t)       chk("R5 STOP with trace on", 32'(traceReq), 1);
        else if (n)       chk("R6 STOP sets trace", 32'(traceReq), 1);
        else              chk("R7 STOP no trace", 32'(traceReq), 0);
        chk("R11 stacked pc", stackPc, expPc);
        chk("R2 stacked sr", 32'(stackSr), 32'(expSr));
        @(negedge clk);
        chk("R9 single pulse / R8 not deferred", 32'(traceReq), 0);
      end
    end

    // R4: instruction before STOP, then STOP with trace cleared by its operand
    drive(32'h0000_0100, 3'd2, 16'h8700, 1'b0, 16'h0000, 1'b0);
    @(negedge clk);
    drive(32'h0000_0104, 3'd2, 16'h8700, 1'b1, 16'h2000, 1'b0);
    chk("R4 pre-STOP trace", 32'(traceReq), 1);
    chk("R4 pre-STOP pc is STOP address", stackPc, 32'h0000_0104);
    @(negedge clk);
    idle();
    chk("R4 STOP trace", 32'(traceReq), 1);
    chk("R4 STOP pc", stackPc, 32'h0000_0108);
    chk("R4 STOP sr", 32'(stackSr), 32'h2000);
    @(negedge clk);

    // R9 back-to-back completions
    drive(32'h0000_2000, 3'd1, 16'h8001, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    drive(32'h0000_2002, 3'd3, 16'h8002, 1'b0, 16'h0, 1'b0);
    chk("R9 first pulse", 32'(traceReq), 1);
    chk("R9 first pc", stackPc, 32'h0000_2002);
    @(negedge clk);
    idle();
    chk("R9 second pulse", 32'(traceReq), 1);
    chk("R9 second pc", stackPc, 32'h0000_2008);
    chk("R9 second sr", 32'(stackSr), 32'h8002);
    @(negedge clk);
    chk("R9 pulse ends", 32'(traceReq), 0);

    // R10 wrap-around
    drive(32'hFFFF_FFFE, 3'd2, 16'h8000, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    idle();
    chk("R10 wrapped pc", stackPc, 32'h0000_0002);
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule